// File: doc/BRIEF.md
# Frequent Value Split Word Store

This block is a small word-addressed data store for 32-bit values that saves upper-array activity for values that recur often. Every stored word keeps a 5-bit low field and a one-bit frequent flag in a narrow array. A separate 27-bit array holds the upper part of words that are not frequent. A 32-entry register file holds the frequent values. When the flag is set, the 5-bit field is an index into that register file and the wide upper array is neither written nor read. When the flag is clear, the word is rebuilt from the upper array and the stored low bits.

The frequent-value register file is filled from outside while the block is in its init phase. A seal pulse then moves the block into its run phase, where reads and writes are served and further table loads are dropped. On a write, the incoming word is compared against every loaded table entry in parallel. A hit stores the matching index with the flag set. A miss stores the raw word with the flag clear. Each read returns its word exactly two cycles after the request, and both the frequent path and the normal path take the same time. The enable of the upper-array read is visible on a port, so the saving can be counted.

Control is a two-state machine. `ST_INIT` accepts table loads and ignores accesses. `ST_RUN` serves accesses and ignores table loads. The transition `ST_INIT -> ST_RUN` is taken on `tbl_seal`. The only way back from `ST_RUN` to `ST_INIT` is reset.

Top module: `fv_split_store`

## Requirements
- R1: After reset the block is in `ST_INIT`. In that state `acc_en` requests are ignored: `rd_valid` and `up_rd_en` stay 0.
- R2: In `ST_INIT`, `tbl_ld_en` writes `tbl_ld_val` into entry `tbl_ld_idx` and marks that entry loaded. A pulse on `tbl_seal` moves the block to `ST_RUN`.
- R3: In `ST_RUN`, table loads are dropped. A value offered by such a load is stored as a normal word, and an entry that was loaded earlier keeps its old value.
- R4: A write whose full 32-bit word equals a loaded entry is stored as frequent. The stored form is the entry index in bits [4:0] of the narrow array, with the flag set. A later read of that word returns the full value with `up_rd_en` low.
- R5: A write that matches no loaded entry is stored raw. Bits [4:0] of the word go to the narrow array and bits [31:5] go to the upper array, with the flag clear. A later read asserts `up_rd_en` for one cycle, in the cycle before `rd_valid`, and returns the word.
- R6: A read accepted at a clock edge produces a one-cycle `rd_valid` pulse two edges later, with `rd_data` valid in that cycle, on either path.
- R7: Entries that were never loaded never match. A word equal to the reset content of such an entry (zero) is stored raw.
- R8: Writes never assert `rd_valid` or `up_rd_en`.
- R9: Overwriting an address updates both the word and its encoding, in either direction between raw and frequent.
- R10: Reads issued on consecutive cycles return their words in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; returns the block to ST_INIT and clears the loaded marks of the table |
| tbl_ld_en | input | 1 | Table load strobe (honoured in ST_INIT only) |
| tbl_ld_idx | input | 5 | Table entry to load |
| tbl_ld_val | input | 32 | Value to load |
| tbl_seal | input | 1 | Ends the init phase |
| acc_en | input | 1 | Access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Word address |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result |
| up_rd_en | output | 1 | Upper-array read enable |

## Verification
A read request driven before edge E0 shows its upper-array enable in the cycle after E0 and its data with `rd_valid` in the cycle after E1. The bench samples at the falling edge in between. Its driver pushes the expected word and path into a queue when it issues the read. The monitor pops the queue whenever `rd_valid` is seen, and compares the `up_rd_en` it sampled at the previous falling edge with the expected path. A dedicated latency check samples `rd_valid` one, two and three falling edges after an isolated request. A running count of upper enables is compared against the count the driver expects.

// File: rtl/fv_pkg.sv
package fv_pkg;

    typedef enum logic [0:0] {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } fv_state_e;

endpackage

// File: rtl/fv_ctrl.sv
module fv_ctrl
    import fv_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_seal,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              ld_allow,
    output logic              wr_go,
    output logic              rd_go,
    output logic              s1_rd,
    output logic [ADDR_W-1:0] s1_addr,
    output logic              s2_rd
);

    fv_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (tbl_seal) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        ld_allow = 1'b0;
        wr_go    = 1'b0;
        rd_go    = 1'b0;
        unique case (state_q)
            ST_INIT: ld_allow = 1'b1;
            ST_RUN: begin
                wr_go = acc_en &&  acc_wr;
                rd_go = acc_en && !acc_wr;
            end
            default: ld_allow = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_rd   <= 1'b0;
            s2_rd   <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_rd   <= rd_go;
            s2_rd   <= s1_rd;
            s1_addr <= acc_addr;
        end
    end

    AST_INIT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> !s1_rd); // R1

endmodule

// File: rtl/fv_value_table.sv
module fv_value_table #(
    parameter int WORD_W = 32,
    parameter int FV_N   = 32,
    parameter int IDX_W  = $clog2(FV_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_allow,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_val,
    input  logic [WORD_W-1:0] srch_val,
    output logic              srch_hit,
    output logic [IDX_W-1:0]  srch_idx,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [WORD_W-1:0] lk_val
);

    logic [WORD_W-1:0] ent_val [FV_N];
    logic [FV_N-1:0]   ent_vld;
    logic [FV_N-1:0]   match;

    always_ff @(posedge clk) begin
        if (!rst_n)                   ent_vld         <= '0;
        else if (ld_en && ld_allow)   ent_vld[ld_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_n && ld_en && ld_allow) ent_val[ld_idx] <= ld_val;
    end

    for (genvar g = 0; g < FV_N; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_val[g] == srch_val);
    end

    always_comb begin
        srch_hit = |match;
        srch_idx = '0;
        for (int i = FV_N - 1; i >= 0; i--) begin
            if (match[i]) srch_idx = IDX_W'(i);
        end
    end

    assign lk_val = ent_val[lk_idx];

    AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_allow |=> $stable(ent_vld)); // R3

    AST_HIT_IS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        srch_hit |-> ent_vld[srch_idx]); // R7

endmodule

// File: rtl/fv_low_array.sv
module fv_low_array #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IDX_W-1:0]  wr_low,
    input  logic              wr_flag,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [IDX_W-1:0]  q_low,
    output logic              q_flag
);

    logic [IDX_W-1:0] low_mem [DEPTH];
    logic [DEPTH-1:0] flag_mem;

    always_ff @(posedge clk) begin
        if (!rst_n)     flag_mem          <= '0;
        else if (wr_en) flag_mem[wr_addr] <= wr_flag;
    end

    always_ff @(posedge clk) begin
        if (wr_en) low_mem[wr_addr] <= wr_low;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_low  <= '0;
            q_flag <= 1'b0;
        end else if (rd_en) begin
            q_low  <= low_mem[rd_addr];
            q_flag <= flag_mem[rd_addr];
        end
    end

endmodule

// File: rtl/fv_upper_array.sv
module fv_upper_array #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int UP_W   = 27
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [UP_W-1:0]   wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [UP_W-1:0]   q
);

    logic [UP_W-1:0] up_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) up_mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) q <= up_mem[rd_addr];
    end

endmodule

// File: rtl/fv_split_store.sv
module fv_split_store #(
    parameter int WORD_W = 32,
    parameter int FV_N   = 32,
    parameter int DEPTH  = 64,
    localparam int IDX_W  = $clog2(FV_N),
    localparam int UP_W   = WORD_W - IDX_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_ld_en,
    input  logic [IDX_W-1:0]  tbl_ld_idx,
    input  logic [WORD_W-1:0] tbl_ld_val,
    input  logic              tbl_seal,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              up_rd_en
);

    logic              ld_allow, wr_go, rd_go, s1_rd, s2_rd;
    logic [ADDR_W-1:0] s1_addr;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  q_low;
    logic              q_flag;
    logic [WORD_W-1:0] lk_val;
    logic [UP_W-1:0]   up_q;
    logic              s2_freq;
    logic [IDX_W-1:0]  s2_low;
    logic [WORD_W-1:0] s2_tbl;

    fv_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tbl_seal(tbl_seal),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .ld_allow(ld_allow), .wr_go(wr_go), .rd_go(rd_go),
        .s1_rd(s1_rd), .s1_addr(s1_addr), .s2_rd(s2_rd)
    );

    fv_value_table #(.WORD_W(WORD_W), .FV_N(FV_N), .IDX_W(IDX_W)) tbl_i (
        .clk(clk), .rst_n(rst_n), .ld_allow(ld_allow),
        .ld_en(tbl_ld_en), .ld_idx(tbl_ld_idx), .ld_val(tbl_ld_val),
        .srch_val(acc_wdata), .srch_hit(hit), .srch_idx(hit_idx),
        .lk_idx(q_low), .lk_val(lk_val)
    );

    fv_low_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) low_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go), .wr_addr(acc_addr),
        .wr_low(hit ? hit_idx : acc_wdata[IDX_W-1:0]), .wr_flag(hit),
        .rd_en(rd_go), .rd_addr(acc_addr),
        .q_low(q_low), .q_flag(q_flag)
    );

    assign up_rd_en = s1_rd && !q_flag;

    fv_upper_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .UP_W(UP_W)) up_i (
        .clk(clk),
        .wr_en(wr_go && !hit), .wr_addr(acc_addr), .wr_data(acc_wdata[WORD_W-1:IDX_W]),
        .rd_en(up_rd_en), .rd_addr(s1_addr), .q(up_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_freq <= 1'b0;
            s2_low  <= '0;
            s2_tbl  <= '0;
        end else if (s1_rd) begin
            s2_freq <= q_flag;
            s2_low  <= q_low;
            s2_tbl  <= lk_val;
        end
    end

    assign rd_valid = s2_rd;
    assign rd_data  = s2_freq ? s2_tbl : {up_q, s2_low};

    AST_READ_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_en && !acc_wr, 2)); // R6

    AST_UPPER_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        up_rd_en |=> rd_valid); // R5

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr) |=> !up_rd_en); // R8

    AST_RUN_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go) |-> ##2 rd_valid); // R10

endmodule

// File: tb/fv_split_store_tb_top.sv
`timescale 1ns/1ps
module fv_split_store_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_ld_en = 1'b0;
    logic [4:0]  tbl_ld_idx = '0;
    logic [31:0] tbl_ld_val = '0;
    logic        tbl_seal = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        up_rd_en;

    always #4 clk = ~clk;

    fv_split_store dut_i (
        .clk(clk), .rst_n(rst_n),
        .tbl_ld_en(tbl_ld_en), .tbl_ld_idx(tbl_ld_idx), .tbl_ld_val(tbl_ld_val),
        .tbl_seal(tbl_seal),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .up_rd_en(up_rd_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    int up_seen = 0;
    int up_exp = 0;
    logic prev_up = 1'b0;
    logic [31:0] q_data [$];
    logic        q_up   [$];
    string       q_req  [$];

    function automatic logic [31:0] fv(input int i);
        return 32'h1000_0000 + i * 32'h0101_0011;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (up_rd_en) up_seen++;
            if (rd_valid) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R8", 32'(rd_valid), 32'd0);
                end else begin
                    automatic logic [31:0] ed = q_data.pop_front();
                    automatic logic        eu = q_up.pop_front();
                    automatic string       rq = q_req.pop_front();
                    chk(rd_data == ed, rq, rd_data, ed);
                    chk(prev_up == eu, rq, 32'(prev_up), 32'(eu));
                end
            end
        end
        prev_up = up_rd_en;
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            acc_en = 1'b0; tbl_ld_en = 1'b0; tbl_seal = 1'b0;
        end
    endtask

    task automatic do_load(input int idx, input logic [31:0] v);
        @(negedge clk);
        acc_en = 1'b0; tbl_ld_en = 1'b1; tbl_ld_idx = 5'(idx); tbl_ld_val = v;
    endtask

    task automatic do_write(input int a, input logic [31:0] v);
        @(negedge clk);
        tbl_ld_en = 1'b0; acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 6'(a); acc_wdata = v;
    endtask

    task automatic do_read(input int a, input logic [31:0] v, input logic freq, input string rq);
        @(negedge clk);
        tbl_ld_en = 1'b0; acc_en = 1'b1; acc_wr = 1'b0; acc_addr = 6'(a);
        q_data.push_back(v); q_up.push_back(!freq); q_req.push_back(rq);
        if (!freq) up_exp++;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'd0);
        chk(up_rd_en == 1'b0, "R1", 32'(up_rd_en), 32'd0);

        // R1: accesses during init are ignored
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 6'd5; acc_wdata = 32'h1234_5678;
        @(negedge clk);
        acc_wr = 1'b0;
        idle(1);
        repeat (3) begin
            @(negedge clk);
            chk(!rd_valid && !up_rd_en, "R1", {30'd0, rd_valid, up_rd_en}, 32'd0);
        end

        // R2: load table then seal
        for (int i = 0; i < 8; i++) do_load(i, fv(i));
        do_load(31, fv(31));
        @(negedge clk);
        tbl_ld_en = 1'b0; tbl_seal = 1'b1;
        idle(2);

        // R3: loads in run are dropped
        do_load(8, 32'hCAFE_BABE);
        do_load(3, 32'h7777_0000);
        idle(1);
        do_write(9, 32'hCAFE_BABE);
        do_write(10, fv(3));
        do_read(9, 32'hCAFE_BABE, 1'b0, "R3");
        do_read(10, fv(3), 1'b1, "R3");
        idle(4);

        // R4: frequent values, R2 entries reachable
        do_write(0, fv(0));
        do_write(1, fv(7));
        do_write(2, fv(31));
        do_read(0, fv(0), 1'b1, "R4");
        do_read(1, fv(7), 1'b1, "R2");
        do_read(2, fv(31), 1'b1, "R4");
        idle(4);

        // R5: raw values
        do_write(3, 32'hA5A5_5A5A);
        do_write(4, 32'h0000_001F);
        do_write(63, 32'hFFFF_FFFF);
        do_read(3, 32'hA5A5_5A5A, 1'b0, "R5");
        do_read(4, 32'h0000_001F, 1'b0, "R5");
        do_read(63, 32'hFFFF_FFFF, 1'b0, "R5");
        idle(4);

        // R7: zero never matches an unloaded entry
        do_write(11, 32'h0000_0000);
        do_read(11, 32'h0000_0000, 1'b0, "R7");
        idle(4);

        // R8: writes raise no strobes
        do_write(12, 32'h0BAD_F00D);
        @(negedge clk);
        acc_en = 1'b0;
        chk(!up_rd_en && !rd_valid, "R8", {30'd0, rd_valid, up_rd_en}, 32'd0);
        @(negedge clk);
        chk(!up_rd_en && !rd_valid, "R8", {30'd0, rd_valid, up_rd_en}, 32'd0);

        // R9: re-encoding on overwrite
        do_write(0, 32'h3141_5926);
        do_write(3, fv(5));
        do_read(0, 32'h3141_5926, 1'b0, "R9");
        do_read(3, fv(5), 1'b1, "R9");
        idle(4);

        // R10: back-to-back reads
        do_read(0, 32'h3141_5926, 1'b0, "R10");
        do_read(1, fv(7), 1'b1, "R10");
        do_read(2, fv(31), 1'b1, "R10");
        do_read(3, fv(5), 1'b1, "R10");
        do_read(4, 32'h0000_001F, 1'b0, "R10");
        do_read(12, 32'h0BAD_F00D, 1'b0, "R10");
        idle(5);

        // R6: exact latency of an isolated read
        do_read(9, 32'hCAFE_BABE, 1'b0, "R6");
        @(negedge clk);
        acc_en = 1'b0;
        chk(rd_valid == 1'b0, "R6", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk(rd_valid == 1'b1, "R6", 32'(rd_valid), 32'd1);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R6", 32'(rd_valid), 32'd0);
        idle(3);

        chk(q_data.size() == 0, "R6", 32'(q_data.size()), 32'd0);
        chk(up_seen == up_exp, "R5", 32'(up_seen), 32'(up_exp));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule